// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

This peripheral guards a system against stalled software. It has a 32-bit up-counter and a compare value. Software programs the compare value and selects what happens when the counter reaches it. The choices can be combined: raise an interrupt, freeze the counter, request an internal reset, request an external reset, or change a level on an external match pin. The reset requests last for a programmable number of clock cycles. A flag records that the watchdog issued a reset. A system reset does not clear this flag, so boot code can read why the last reset happened. Only a separate power-on reset clears it. The counter can also be frozen while a debugger halts the processor.

Software reaches eight word registers over a simple bus. Writes take effect at a clock edge. Reads are combinational. To keep the system alive, software clears the counter with a clear command and then enables the counter again. The clear command finishes one cycle after it is written. Software sees that it has finished when the counter reads zero.

Two small state machines do the work. The counter machine has two states. In `CS_RUN` the counter counts while it is enabled, not frozen and not being cleared. It goes from `CS_RUN` to `CS_HELD` on a match when stop-on-match is set. It goes from `CS_HELD` back to `CS_RUN` when a clear command completes. The pulse machine also has two states. It goes from `PS_IDLE` to `PS_DRIVE` when a match occurs and a reset request is selected. It goes from `PS_DRIVE` back to `PS_IDLE` when its remaining-length count reaches zero.

Top module: `wdt_timer`

## Requirements
- R1: After `rst_n` is released (with `por_n` also pulsed), every register reads 0 and `irq`, `int_rst_req`, `ext_rst_out` and `ext_match_out` are low.
- R2: The register map uses word index `bus_addr[4:2]`:
  - 0 = interrupt flag (bit 0)
  - 1 = control (bit 0 enable, bit 1 clear command, bit 2 debug freeze)
  - 2 = counter
  - 3 = match control (bits 0, 2, 3, 4, 5, 6)
  - 4 = match value
  - 5 = external match (bit 0 pin state, bits 5:4 mode)
  - 6 = pulse length (bits 15:0)
  - 7 = reset cause (bit 0, read-only)
  
  Bits that are not listed read 0. Writes to index 7 have no effect.
- R3: While control bit 0 is 1, the counter rises by one on every clock edge, starting at the edge after the write. Writing 0 to control stops the counter and keeps its value.
- R4: Writing control bit 1 zeroes the counter at the next edge. Control bit 1 then reads 0 again.
- R5: While control bit 2 is 1 and `dbg_halt` is high, the counter holds its value.
- R6: A match is the edge at which an advancing counter reaches the match value. If match control bit 0 is set, the match sets the interrupt flag, which drives `irq`. Writing 1 to bit 0 of index 0 clears the flag. A match in the same cycle as the clear wins.
- R7: If match control bit 2 is set, the counter stays at the match value after a match, until a clear command.
- R8: If match control bit 3 is set, a match drives `int_rst_req` high for (pulse length + 1) cycles, starting the cycle after the match edge. Match control bit 4 does the same for `ext_rst_out`. A match during a pulse is ignored.
- R9: Match control bit 5 holds `int_rst_req` high while it is set. Bit 6 does the same for `ext_rst_out`. Neither bit depends on the counter.
- R10: On a match, the mode in bits 5:4 of index 5 acts on `ext_match_out`:
  - 2 drives it high.
  - 1 drives it low.
  - 3 toggles it.
  - 0 leaves it unchanged.
  
  Software can also write the pin directly through bit 0.
- R11: Bit 0 of index 7 becomes 1 when a reset pulse starts. It keeps its value through `rst_n` and is cleared only by `por_n`.
- R12: No match occurs while the counter is not advancing, for example when it is disabled or frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| por_n | input | 1 | Active-low power-on reset; the only reset that clears the reset-cause flag |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 5 | Byte address; bits 4:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| dbg_halt | input | 1 | Debugger halt indication |
| irq | output | 1 | Match interrupt flag |
| int_rst_req | output | 1 | Internal reset request |
| ext_rst_out | output | 1 | External reset output |
| ext_match_out | output | 1 | External match pin |

## Verification
The bench targets several corner cases where a wrong design fails in a visible way:
- **Clear command timing.** Control bit 1 must read 1 for exactly one cycle. A design that clears the counter at the wrong edge shows a nonzero counter. A design whose command sticks keeps reading 1.
- **Pulse length.** High cycles are counted and must equal the pulse length plus one. A second match is forced during a running pulse. A design that restarts the pulse would stretch the count.
- **Stop on match.** A design that keeps matching while the counter is held would show the counter creeping past the match value.
- **Reset-cause flag.** The flag is checked across a system reset and then across a power-on reset. A design that puts the flag on the wrong reset loses it in the first case.
- **External pin modes.** Each of the four modes is checked, including the direct write that a match with mode 0 must leave untouched.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int REG_IDX_W = 3;

    localparam logic [REG_IDX_W-1:0] IDX_IRQ   = 3'd0;
    localparam logic [REG_IDX_W-1:0] IDX_CTRL  = 3'd1;
    localparam logic [REG_IDX_W-1:0] IDX_COUNT = 3'd2;
    localparam logic [REG_IDX_W-1:0] IDX_MCTL  = 3'd3;
    localparam logic [REG_IDX_W-1:0] IDX_MVAL  = 3'd4;
    localparam logic [REG_IDX_W-1:0] IDX_XMATCH = 3'd5;
    localparam logic [REG_IDX_W-1:0] IDX_PLEN  = 3'd6;
    localparam logic [REG_IDX_W-1:0] IDX_CAUSE = 3'd7;

    // match control bit positions (decoded by the counter and pulse logic)
    localparam int MC_IRQ    = 0;
    localparam int MC_STOP   = 2;
    localparam int MC_RINT   = 3;
    localparam int MC_REXT   = 4;
    localparam int MC_FINT   = 5;
    localparam int MC_FEXT   = 6;
    localparam int MC_W      = 7;
    localparam logic [MC_W-1:0] MC_MASK = 7'h7D;

    typedef enum logic [1:0] {
        XM_NONE   = 2'd0,
        XM_LOW    = 2'd1,
        XM_HIGH   = 2'd2,
        XM_TOGGLE = 2'd3
    } xmatch_mode_e;

    typedef enum logic {
        CS_RUN  = 1'b0,
        CS_HELD = 1'b1
    } cnt_state_e;

    typedef enum logic {
        PS_IDLE  = 1'b0,
        PS_DRIVE = 1'b1
    } pulse_state_e;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             freeze_en,
    input  logic             dbg_halt,
    input  logic             clear,
    input  logic             stop_on_match,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic             hit,
    output logic             held
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] next_val;
    logic             advance;

    always_comb begin
        advance  = (state_q == CS_RUN) && count_en && !(freeze_en && dbg_halt) && !clear;
        next_val = count + CNT_W'(1);
        hit      = advance && (next_val == match_val);
        state_d  = state_q;
        unique case (state_q)
            CS_RUN:  if (hit && stop_on_match) state_d = CS_HELD;
            CS_HELD: if (clear)                state_d = CS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (clear)   count <= '0;
        else if (advance) count <= next_val;
    end

    assign held = (state_q == CS_HELD);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse
    import wdt_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             sel_int,
    input  logic             sel_ext,
    input  logic [LEN_W-1:0] len,
    output logic             drive_int,
    output logic             drive_ext,
    output logic             fire,
    output logic             busy,
    output logic [LEN_W-1:0] remain
);
    pulse_state_e state_q, state_d;
    logic         si_q, se_q;

    always_comb begin
        fire    = (state_q == PS_IDLE) && trig && (sel_int || sel_ext);
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:  if (fire)          state_d = PS_DRIVE;
            PS_DRIVE: if (remain == '0)  state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            remain  <= '0;
            si_q    <= 1'b0;
            se_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fire) begin
                remain <= len;
                si_q   <= sel_int;
                se_q   <= sel_ext;
            end else if (state_q == PS_DRIVE && remain != '0) begin
                remain <= remain - LEN_W'(1);
            end
        end
    end

    always_comb begin
        busy      = (state_q == PS_DRIVE);
        drive_int = busy && si_q;
        drive_ext = busy && se_q;
    end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        dbg_halt,
    output logic        irq,
    output logic        int_rst_req,
    output logic        ext_rst_out,
    output logic        ext_match_out
);
    localparam int DATA_W = 32;

    logic                 wr;
    logic [REG_IDX_W-1:0] idx;
    logic                 unused_addr_lsb;

    logic             en_q, clr_q, frz_q, irq_q, xpin_q, cause_q;
    logic [MC_W-1:0]  mc_q;
    logic [CNT_W-1:0] match_q;
    logic [LEN_W-1:0] plen_q;
    xmatch_mode_e     xmode_q;

    logic [CNT_W-1:0] cnt_w;
    logic             hit_w, held_w;
    logic             drv_int_w, drv_ext_w, fire_w, busy_w;
    logic [LEN_W-1:0] rem_w;

    assign wr              = bus_sel && bus_we;
    assign idx             = bus_addr[4:2];
    assign unused_addr_lsb = ^bus_addr[1:0];

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .count_en      (en_q),
        .freeze_en     (frz_q),
        .dbg_halt      (dbg_halt),
        .clear         (clr_q),
        .stop_on_match (mc_q[MC_STOP]),
        .match_val     (match_q),
        .count         (cnt_w),
        .hit           (hit_w),
        .held          (held_w)
    );

    wdt_pulse #(.LEN_W(LEN_W)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (hit_w),
        .sel_int   (mc_q[MC_RINT]),
        .sel_ext   (mc_q[MC_REXT]),
        .len       (plen_q),
        .drive_int (drv_int_w),
        .drive_ext (drv_ext_w),
        .fire      (fire_w),
        .busy      (busy_w),
        .remain    (rem_w)
    );

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            clr_q   <= 1'b0;
            frz_q   <= 1'b0;
            mc_q    <= '0;
            match_q <= '0;
            plen_q  <= '0;
            xmode_q <= XM_NONE;
        end else begin
            clr_q <= 1'b0;
            if (wr) begin
                unique case (idx)
                    IDX_CTRL:   {frz_q, clr_q, en_q} <= bus_wdata[2:0];
                    IDX_MCTL:   mc_q    <= bus_wdata[MC_W-1:0] & MC_MASK;
                    IDX_MVAL:   match_q <= bus_wdata[CNT_W-1:0];
                    IDX_XMATCH: xmode_q <= xmatch_mode_e'(bus_wdata[5:4]);
                    IDX_PLEN:   plen_q  <= bus_wdata[LEN_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // interrupt flag: match set wins over software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    irq_q <= 1'b0;
        else if (hit_w && mc_q[MC_IRQ])                irq_q <= 1'b1;
        else if (wr && idx == IDX_IRQ && bus_wdata[0]) irq_q <= 1'b0;
    end

    // external match pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xpin_q <= 1'b0;
        end else if (hit_w && xmode_q != XM_NONE) begin
            unique case (xmode_q)
                XM_LOW:    xpin_q <= 1'b0;
                XM_HIGH:   xpin_q <= 1'b1;
                XM_TOGGLE: xpin_q <= !xpin_q;
                default:   xpin_q <= xpin_q;
            endcase
        end else if (wr && idx == IDX_XMATCH) begin
            xpin_q <= bus_wdata[0];
        end
    end

    // reset cause survives the system reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      cause_q <= 1'b0;
        else if (fire_w) cause_q <= 1'b1;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_IRQ:    bus_rdata[0]   = irq_q;
            IDX_CTRL:   bus_rdata[2:0] = {frz_q, clr_q, en_q};
            IDX_COUNT:  bus_rdata      = DATA_W'(cnt_w);
            IDX_MCTL:   bus_rdata[MC_W-1:0] = mc_q;
            IDX_MVAL:   bus_rdata      = DATA_W'(match_q);
            IDX_XMATCH: bus_rdata[5:0] = {xmode_q, 3'b000, xpin_q};
            IDX_PLEN:   bus_rdata      = DATA_W'(plen_q);
            IDX_CAUSE:  bus_rdata[0]   = cause_q;
        endcase
    end

    assign irq           = irq_q;
    assign int_rst_req   = drv_int_w || mc_q[MC_FINT];
    assign ext_rst_out   = drv_ext_w || mc_q[MC_FEXT];
    assign ext_match_out = xpin_q;
endmodule

// File: rtl/wdt_timer_checker.sv
module wdt_timer_checker #(
    parameter int CNT_W = 32,
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             por_n,
    input logic             clr,
    input logic             en,
    input logic             frz,
    input logic             dbg_halt,
    input logic [CNT_W-1:0] cnt,
    input logic             held,
    input logic             hit,
    input logic             irq_en,
    input logic             irq,
    input logic             busy,
    input logic [LEN_W-1:0] rem,
    input logic             cause
);
    a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    a_r7_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        held && !clr |=> $stable(cnt));

    a_r5_debug_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        en && frz && dbg_halt && !clr |=> $stable(cnt));

    a_r6_irq_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        hit && irq_en |=> irq);

    a_r8_pulse_runs: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rem != '0 |=> busy);

    a_r8_pulse_stops: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rem == '0 |=> !busy);

    a_r11_cause_sticky: assert property (@(posedge clk) disable iff (!por_n)
        cause |=> cause);
endmodule

bind wdt_timer wdt_timer_checker #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_n    (por_n),
    .clr      (clr_q),
    .en       (en_q),
    .frz      (frz_q),
    .dbg_halt (dbg_halt),
    .cnt      (cnt_w),
    .held     (held_w),
    .hit      (hit_w),
    .irq_en   (mc_q[0]),
    .irq      (irq),
    .busy     (busy_w),
    .rem      (rem_w),
    .cause    (cause_q)
);

// File: tb/wdt_timer_test.sv
module wdt_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        irq, int_rst_req, ext_rst_out, ext_match_out;

    int checks = 0, fails = 0;
    int n_int = 0, n_ext = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wdt_timer uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
        .irq(irq), .int_rst_req(int_rst_req), .ext_rst_out(ext_rst_out),
        .ext_match_out(ext_match_out)
    );

    // behavioural reference model
    logic [31:0] m_cnt, m_match;
    logic        m_en, m_clr, m_frz, m_held, m_irq, m_ext, m_cause, m_psi, m_pse;
    logic [6:0]  m_mc;
    logic [1:0]  m_mode;
    logic [15:0] m_plen;
    int          m_prem;

    always @(posedge clk) begin : model
        logic        adv, hit, wr;
        logic [31:0] nxt;
        logic [2:0]  ix;
        if (!por_n) m_cause = 1'b0;
        if (!rst_n) begin
            m_cnt = 0; m_match = 0; m_en = 0; m_clr = 0; m_frz = 0; m_held = 0;
            m_irq = 0; m_ext = 0; m_mc = 0; m_mode = 0; m_plen = 0;
            m_prem = -1; m_psi = 0; m_pse = 0;
        end else begin
            wr  = bus_sel && bus_we;
            ix  = bus_addr[4:2];
            adv = m_en && !m_held && !(m_frz && dbg_halt) && !m_clr;
            nxt = m_cnt + 32'd1;
            hit = adv && (nxt == m_match);
            if (m_prem >= 0) m_prem = (m_prem == 0) ? -1 : m_prem - 1;
            else if (hit && (m_mc[3] || m_mc[4])) begin
                m_prem = int'(m_plen); m_psi = m_mc[3]; m_pse = m_mc[4]; m_cause = 1'b1;
            end
            if (hit && m_mc[0]) m_irq = 1'b1;
            else if (wr && ix == 3'd0 && bus_wdata[0]) m_irq = 1'b0;
            if (hit && m_mode == 2'd2) m_ext = 1'b1;
            else if (hit && m_mode == 2'd1) m_ext = 1'b0;
            else if (hit && m_mode == 2'd3) m_ext = !m_ext;
            else if (wr && ix == 3'd5) m_ext = bus_wdata[0];
            if (m_clr) begin m_cnt = 0; m_held = 0; end
            else if (adv) begin m_cnt = nxt; if (hit && m_mc[2]) m_held = 1'b1; end
            m_clr = 1'b0;
            if (wr) case (ix)
                3'd1: {m_frz, m_clr, m_en} = bus_wdata[2:0];
                3'd3: m_mc    = bus_wdata[6:0] & 7'h7D;
                3'd4: m_match = bus_wdata;
                3'd5: m_mode  = bus_wdata[5:4];
                3'd6: m_plen  = bus_wdata[15:0];
                default: ;
            endcase
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] ix);
        case (ix)
            3'd0: return {31'd0, m_irq};
            3'd1: return {29'd0, m_frz, m_clr, m_en};
            3'd2: return m_cnt;
            3'd3: return {25'd0, m_mc};
            3'd4: return m_match;
            3'd5: return {26'd0, m_mode, 3'b000, m_ext};
            3'd6: return {16'd0, m_plen};
            default: return {31'd0, m_cause};
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && por_n && !done) begin
            chk("R6", "irq", {31'd0, irq}, {31'd0, m_irq});
            chk("R8", "int_rst_req", {31'd0, int_rst_req}, {31'd0, (m_prem >= 0 && m_psi) || m_mc[5]});
            chk("R8", "ext_rst_out", {31'd0, ext_rst_out}, {31'd0, (m_prem >= 0 && m_pse) || m_mc[6]});
            chk("R10", "ext_match_out", {31'd0, ext_match_out}, {31'd0, m_ext});
        end
        if (int_rst_req) n_int++;
        if (ext_rst_out) n_ext++;
    end

    task automatic wr(input logic [2:0] ix, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {ix, 2'b00}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rdx(input logic [2:0] ix, input logic [31:0] exp, input string req);
        bus_addr = {ix, 2'b00};
        #1;
        chk(req, "read literal", bus_rdata, exp);
        chk(req, "read model", bus_rdata, m_read(ix));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart;
        wr(3'd1, 32'h2);
        idle(1);
        wr(3'd1, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 8; i++) rdx(3'(i), 32'h0, "R1");
        chk("R1", "outputs", {28'd0, irq, int_rst_req, ext_rst_out, ext_match_out}, 32'h0);
        // R2 map, unused bits, read-only cause; R9 force bits
        wr(3'd3, 32'hFFFF_FFFF);
        rdx(3'd3, 32'h7D, "R2");
        chk("R9", "forced both", {30'd0, int_rst_req, ext_rst_out}, 32'h3);
        wr(3'd3, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        rdx(3'd5, 32'h31, "R2");
        wr(3'd5, 32'h0);
        wr(3'd7, 32'hFFFF_FFFF);
        rdx(3'd7, 32'h0, "R2");
        wr(3'd6, 32'hFFFF_FFFF);
        rdx(3'd6, 32'hFFFF, "R2");
        wr(3'd1, 32'hFFFF_FFF8);
        rdx(3'd1, 32'h0, "R2");
        // R3 counting and stop
        wr(3'd4, 32'hFFFF_FFF0);
        wr(3'd1, 32'h1);
        idle(10);
        rdx(3'd2, 32'd10, "R3");
        wr(3'd1, 32'h0);
        rdx(3'd2, 32'd12, "R3");
        idle(5);
        rdx(3'd2, 32'd12, "R3");
        // R4 clear command
        wr(3'd1, 32'h2);
        rdx(3'd1, 32'h2, "R4");
        idle(1);
        rdx(3'd2, 32'h0, "R4");
        rdx(3'd1, 32'h0, "R4");
        // R5 debug freeze
        wr(3'd1, 32'h5);
        idle(4);
        rdx(3'd2, 32'd4, "R5");
        dbg_halt = 1'b1;
        idle(6);
        rdx(3'd2, 32'd4, "R5");
        dbg_halt = 1'b0;
        idle(3);
        rdx(3'd2, 32'd7, "R5");
        wr(3'd1, 32'h1);
        dbg_halt = 1'b1;
        idle(3);
        rdx(3'd2, m_read(3'd2), "R5");
        dbg_halt = 1'b0;
        wr(3'd1, 32'h2);
        idle(1);
        // R6 R8 R10 R11 match with both reset requests
        wr(3'd6, 32'd3);
        wr(3'd4, 32'd20);
        wr(3'd5, 32'h20);
        wr(3'd3, 32'h19);
        n_int = 0; n_ext = 0;
        wr(3'd1, 32'h1);
        idle(30);
        chk("R8", "int pulse cycles", 32'(n_int), 32'd4);
        chk("R8", "ext pulse cycles", 32'(n_ext), 32'd4);
        chk("R6", "irq after match", {31'd0, irq}, 32'h1);
        chk("R10", "pin high mode", {31'd0, ext_match_out}, 32'h1);
        rdx(3'd7, 32'h1, "R11");
        wr(3'd0, 32'h1);
        rdx(3'd0, 32'h0, "R6");
        // R8 second match during a running pulse is ignored
        wr(3'd1, 32'h2);
        idle(1);
        wr(3'd6, 32'd40);
        wr(3'd4, 32'd5);
        n_int = 0;
        wr(3'd1, 32'h1);
        idle(8);
        restart;
        idle(60);
        chk("R8", "no retrigger", 32'(n_int), 32'd41);
        // R7 stop on match
        wr(3'd1, 32'h2);
        idle(1);
        wr(3'd3, 32'h05);
        wr(3'd4, 32'd8);
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h1);
        idle(20);
        rdx(3'd2, 32'd8, "R7");
        chk("R6", "irq stop case", {31'd0, irq}, 32'h1);
        wr(3'd1, 32'h3);
        idle(3);
        rdx(3'd2, m_read(3'd2), "R7");
        // R12 no match without advance
        wr(3'd1, 32'h2);
        idle(1);
        wr(3'd0, 32'h1);
        wr(3'd3, 32'h01);
        wr(3'd4, 32'd1);
        idle(10);
        chk("R12", "disabled irq", {31'd0, irq}, 32'h0);
        dbg_halt = 1'b1;
        wr(3'd1, 32'h5);
        idle(10);
        chk("R12", "frozen irq", {31'd0, irq}, 32'h0);
        rdx(3'd2, 32'h0, "R12");
        dbg_halt = 1'b0;
        // R10 remaining modes
        wr(3'd1, 32'h2);
        idle(1);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'd3);
        wr(3'd5, 32'h30);
        wr(3'd1, 32'h1);
        idle(6);
        chk("R10", "toggle up", {31'd0, ext_match_out}, 32'h1);
        restart;
        idle(6);
        chk("R10", "toggle down", {31'd0, ext_match_out}, 32'h0);
        wr(3'd5, 32'h11);
        restart;
        idle(6);
        chk("R10", "low mode", {31'd0, ext_match_out}, 32'h0);
        wr(3'd5, 32'h01);
        restart;
        idle(6);
        chk("R10", "mode none keeps", {31'd0, ext_match_out}, 32'h1);
        // R9 force bits
        wr(3'd3, 32'h20);
        chk("R9", "force int", {30'd0, int_rst_req, ext_rst_out}, 32'h2);
        wr(3'd3, 32'h40);
        chk("R9", "force ext", {30'd0, int_rst_req, ext_rst_out}, 32'h1);
        wr(3'd3, 32'h0);
        // R11 cause across system reset, then power-on reset
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        rdx(3'd7, 32'h1, "R11");
        rdx(3'd1, 32'h0, "R1");
        rst_n = 1'b0; por_n = 1'b0;
        idle(2);
        rst_n = 1'b1; por_n = 1'b1;
        idle(1);
        rdx(3'd7, 32'h0, "R11");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule